// File: doc/BRIEF.md
# RLL (2,7) Serial Encoder

This block turns a serial data stream into a run-length-limited (2,7) channel stream for a magnetic recording write path. Data bits enter one at a time through a valid/ready handshake. The block gathers them in a small shift buffer. It cuts the stream into prefix-free groups of two, three or four bits, taking them greedily from the oldest buffered bit. Each group is replaced by a codeword of twice its length. A serializer sends the codeword out one channel bit per clock. Because the code has rate 1/2, the output side runs at twice the average input rate. The input therefore sees back-pressure whenever the buffer is full.

A flush request closes a record. Any trailing bits that do not yet form a group are padded with zeros until a group forms. That last codeword is sent, and the block then returns to idle and accepts new data.

Control is one state machine with four states:
- ST_IDLE: no codeword is in flight.
- ST_RUN: codewords are being shifted out.
- ST_PAD: flush is in progress and zeros are being appended to the leftover bits.
- ST_DRAIN: flush is in progress, the buffer is empty, and the last codeword is finishing.

Transitions:
- IDLE→RUN on the first codeword load.
- RUN→IDLE when the last bit of a codeword leaves and no group is ready.
- IDLE/RUN→PAD when a flush is pending, no group can be decided and bits remain.
- PAD→DRAIN when the buffer becomes empty.
- DRAIN→IDLE when the serializer finishes, which also clears the flush.
- IDLE clears a pending flush at once if the buffer is empty.

Top module: `rll27_encoder`

## Requirements
- R1: A group starting with 1 is two bits long. Group 10 is sent as 0100 and group 11 is sent as 1000.
- R2: The three-bit groups are encoded as follows: 000 as 000100, 010 as 100100 and 011 as 001000.
- R3: The four-bit groups are encoded as follows: 0010 as 00100100 and 0011 as 00001000.
- R4: Groups are parsed greedily in arrival order, with the first accepted bit as the group's leftmost bit. Codewords are emitted leftmost bit first, and each codeword is exactly twice as long as its group.
- R5: The output carries one code bit per clock while out_valid is high. Consecutive codewords follow with no idle clock as long as the input keeps the buffer supplied. out_valid is low in ST_IDLE.
- R6: in_ready falls when the buffer holds four unconsumed bits. No accepted bit is lost or duplicated.
- R7: In the output stream, every run of zeros between two ones is at least 2 and at most 7 bits long.
- R8: On flush, the leftover bits are padded with zeros into one final group. The leftovers map as follows: 1 becomes 0100; 0 and 00 become 000100; 01 becomes 100100; 001 becomes 00100100.
- R9: A bit accepted in the same clock as flush belongs to the flushed record. in_ready is low from the clock after flush until the final codeword has been sent. The block then returns to idle with in_ready high.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_bit holds a data bit |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Block can accept a data bit this clock |
| flush | input | 1 | One-clock request to pad and close the current record |
| out_valid | output | 1 | out_bit holds a code bit |
| out_bit | output | 1 | Serial RLL (2,7) code bit |

## Verification
Two events can share a clock. The last data bit of a record can be accepted in the same clock that flush is raised. Separately, the serializer can be emitting the final bit of one codeword while the parser loads the next one. The bench raises flush together with the handshake of a trailing bit that cannot yet form a group. It then judges the result by the exact padded codeword sequence and by in_ready being low in the following clock. Back-to-back loading is provoked with a gap-free input stream and judged by out_valid rising only once over the whole stream. The output is also decoded with the inverse table and checked for zero-run bounds.

// File: rtl/rll27_pkg.sv
package rll27_pkg;
    // longest data group and derived codeword / counter widths
    localparam int GRP_MAX = 4;
    localparam int CW_W    = 2 * GRP_MAX;
    localparam int LEN_W   = $clog2(GRP_MAX + 1);
    localparam int LEFT_W  = $clog2(CW_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_PAD,
        ST_DRAIN
    } enc_state_e;
endpackage

// File: rtl/rll27_shift_buf.sv
module rll27_shift_buf #(
    parameter int DEPTH = 4,
    parameter int LEN_W = 3,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_bit,
    input  logic [LEN_W-1:0] pop_len,
    output logic [DEPTH-1:0] bits,
    output logic [CNT_W-1:0] cnt
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [DEPTH-1:0] bits_n;
    logic [CNT_W-1:0] cnt_mid;
    logic [CNT_W-1:0] cnt_n;

    // bit 0 is the oldest; consumed bits leave at the low end
    always_comb begin
        bits_n  = bits >> pop_len;
        cnt_mid = cnt - CNT_W'(pop_len);
        if (push && (cnt_mid < DEPTH_C)) begin
            bits_n[cnt_mid[IDX_W-1:0]] = push_bit;
        end
        cnt_n = cnt_mid + {{(CNT_W-1){1'b0}}, push};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits <= '0;
            cnt  <= '0;
        end else begin
            bits <= bits_n;
            cnt  <= cnt_n;
        end
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_C);

    p_no_overfill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_mid < DEPTH_C));

    p_pop_avail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_len != '0) |-> (CNT_W'(pop_len) <= cnt));
endmodule

// File: rtl/rll27_group_parse.sv
module rll27_group_parse
    import rll27_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] bits,
    input  logic [CNT_W-1:0] cnt,
    output logic             grp_ok,
    output logic [LEN_W-1:0] grp_len,
    output logic [CW_W-1:0]  cw
);
    logic b0, b1, b2, b3;
    logic have2, have3, have4;

    assign b0 = bits[0];
    assign b1 = bits[1];
    assign b2 = bits[2];
    assign b3 = bits[3];
    assign have2 = (cnt >= CNT_W'(2));
    assign have3 = (cnt >= CNT_W'(3));
    assign have4 = (cnt >= CNT_W'(4));

    // greedy prefix match from the oldest bit; codeword left-aligned
    always_comb begin
        grp_ok  = 1'b0;
        grp_len = '0;
        cw      = '0;
        if (have2 && b0) begin
            grp_ok  = 1'b1;
            grp_len = LEN_W'(2);
            cw      = b1 ? 8'b1000_0000 : 8'b0100_0000;
        end else if (have3 && !b0 && b1) begin
            grp_ok  = 1'b1;
            grp_len = LEN_W'(3);
            cw      = b2 ? 8'b0010_0000 : 8'b1001_0000;
        end else if (have3 && !b0 && !b1 && !b2) begin
            grp_ok  = 1'b1;
            grp_len = LEN_W'(3);
            cw      = 8'b0001_0000;
        end else if (have4 && !b0 && !b1 && b2) begin
            grp_ok  = 1'b1;
            grp_len = LEN_W'(4);
            cw      = b3 ? 8'b0000_1000 : 8'b0010_0100;
        end
    end
endmodule

// File: rtl/rll27_serializer.sv
module rll27_serializer
    import rll27_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CW_W-1:0]   cw,
    input  logic [LEN_W-1:0]  len,
    output logic              out_bit,
    output logic              out_valid,
    output logic [LEFT_W-1:0] left
);
    logic [CW_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= cw;
            left <= LEFT_W'({len, 1'b0});
        end else if (left != '0) begin
            sreg <= {sreg[CW_W-2:0], 1'b0};
            left <= left - LEFT_W'(1);
        end
    end

    assign out_bit   = sreg[CW_W-1];
    assign out_valid = (left != '0);

    p_load_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (left <= LEFT_W'(1)));

    p_stream_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (left > LEFT_W'(1)) |=> out_valid);
endmodule

// File: rtl/rll27_encoder.sv
module rll27_encoder
    import rll27_pkg::*;
#(
    parameter int DEPTH = GRP_MAX
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic in_ready,
    input  logic flush,
    output logic out_valid,
    output logic out_bit
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    enc_state_e        state, state_n;
    logic              flush_pend, flush_clr;
    logic              load, pad_push, push, push_bit;
    logic [LEN_W-1:0]  pop_len;
    logic [DEPTH-1:0]  bits;
    logic [CNT_W-1:0]  cnt;
    logic              grp_ok;
    logic [LEN_W-1:0]  grp_len;
    logic [CW_W-1:0]   cw;
    logic [LEFT_W-1:0] ser_left;
    logic              ser_free;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            flush_pend <= 1'b0;
        end else begin
            state      <= state_n;
            flush_pend <= (flush_pend & ~flush_clr) | flush;
        end
    end

    assign ser_free = (ser_left <= LEFT_W'(1));

    // outputs and next state
    always_comb begin
        in_ready  = !flush_pend && (cnt < DEPTH_C);
        load      = grp_ok && ser_free;
        pad_push  = 1'b0;
        flush_clr = 1'b0;
        state_n   = state;
        unique case (state)
            ST_IDLE: begin
                if (load) begin
                    state_n = ST_RUN;
                end else if (flush_pend) begin
                    if (cnt != '0) state_n = ST_PAD;
                    else           flush_clr = 1'b1;
                end
            end
            ST_RUN: begin
                if (flush_pend && !grp_ok && (cnt != '0)) begin
                    state_n = ST_PAD;
                end else if ((ser_left == LEFT_W'(1)) && !load) begin
                    state_n = ST_IDLE;
                end
            end
            ST_PAD: begin
                pad_push = !grp_ok && (cnt != '0);
                if (cnt == '0) state_n = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (ser_free) begin
                    state_n   = ST_IDLE;
                    flush_clr = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        push     = (in_valid && in_ready) || pad_push;
        push_bit = pad_push ? 1'b0 : in_bit;
        pop_len  = load ? grp_len : '0;
    end

    rll27_shift_buf #(
        .DEPTH (DEPTH),
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_bit (push_bit),
        .pop_len  (pop_len),
        .bits     (bits),
        .cnt      (cnt)
    );

    rll27_group_parse #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_parse (
        .bits    (bits),
        .cnt     (cnt),
        .grp_ok  (grp_ok),
        .grp_len (grp_len),
        .cw      (cw)
    );

    rll27_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cw        (cw),
        .len       (grp_len),
        .out_bit   (out_bit),
        .out_valid (out_valid),
        .left      (ser_left)
    );

    // zero-run tracking of the emitted stream, for the R7 properties
    logic [3:0] zrun;
    logic       seen_one;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zrun     <= '0;
            seen_one <= 1'b0;
        end else if (out_valid) begin
            if (out_bit) begin
                zrun     <= '0;
                seen_one <= 1'b1;
            end else if (zrun != 4'hF) begin
                zrun <= zrun + 4'd1;
            end
        end
    end

    p_zero_run_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_bit && seen_one) |-> (zrun < 4'd7));

    p_zero_run_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bit && seen_one) |-> (zrun >= 4'd2));

    p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !in_ready);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !out_valid);

    p_drain_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (cnt == '0));

    p_pad_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pad_push |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: tb/rll27_encoder_tb.sv
module rll27_encoder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic flush = 1'b0;
    logic in_ready, out_valid, out_bit;

    always #4 clk = ~clk;

    rll27_encoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .flush     (flush),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic src  [0:2047];
    logic expd [0:4095];
    logic got  [0:4095];
    logic dec  [0:4095];
    int n_src, n_exp, n_got, n_dec;
    int rises, bp_seen;
    logic prev_ov = 1'b0;

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (n_got < 4096) got[n_got] = out_bit;
                n_got++;
            end
            if (out_valid && !prev_ov) rises++;
            prev_ov = out_valid;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    function automatic logic sget(input int i);
        return (i < n_src) ? src[i] : 1'b0;
    endfunction

    task automatic emit(input logic [7:0] pat, input int len);
        for (int k = 0; k < len; k++) begin
            expd[n_exp] = pat[len-1-k];
            n_exp++;
        end
    endtask

    // reference encoding from the code table, zero padding past the end
    task automatic build_expected();
        int i = 0;
        n_exp = 0;
        while (i < n_src) begin
            if (sget(i)) begin
                emit(sget(i+1) ? 8'b1000 : 8'b0100, 4);
                i += 2;
            end else if (sget(i+1)) begin
                emit(sget(i+2) ? 8'b001000 : 8'b100100, 6);
                i += 3;
            end else if (!sget(i+2)) begin
                emit(8'b000100, 6);
                i += 3;
            end else begin
                emit(sget(i+3) ? 8'b00001000 : 8'b00100100, 8);
                i += 4;
            end
        end
    endtask

    task automatic cmp_stream(input string req, input string what);
        int bad = -1;
        if (n_got == n_exp) begin
            for (int k = 0; k < n_got; k++)
                if (bad < 0 && got[k] !== expd[k]) bad = k;
        end
        if (n_got != n_exp)
            check(1'b0, req, {what, " length"}, n_got, n_exp);
        else
            check(bad < 0, req, {what, " first bad bit index"}, bad, -1);
    endtask

    task automatic send_bit(input logic b, input bit with_flush);
        in_valid = 1'b1;
        in_bit   = b;
        while (!in_ready) begin
            bp_seen++;
            @(negedge clk);
        end
        flush = with_flush;
        @(negedge clk);
        in_valid = 1'b0;
        flush    = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 10) begin
            @(negedge clk);
            if (!out_valid && in_ready) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic start_case();
        wait_idle();
        n_src = 0; n_got = 0; rises = 0; bp_seen = 0;
    endtask

    task automatic load_str(input string s);
        for (int k = 0; k < s.len(); k++) begin
            src[n_src] = (s[k] == "1");
            n_src++;
        end
    endtask

    task automatic add_group(input int kind);
        case (kind)
            0: load_str("10");
            1: load_str("11");
            2: load_str("000");
            3: load_str("010");
            4: load_str("011");
            5: load_str("0010");
            default: load_str("0011");
        endcase
    endtask

    task automatic run_str(input string s, input bit do_flush,
                           input string req, input string what);
        start_case();
        load_str(s);
        for (int k = 0; k < n_src; k++) send_bit(src[k], 1'b0);
        if (do_flush) pulse_flush();
        wait_idle();
        build_expected();
        cmp_stream(req, what);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R10", "in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after reset",
              int'({out_valid, in_ready}), 1);
    endtask

    task automatic t_two_bit_groups();
        run_str("10", 1'b0, "R1", "group 10 -> 0100");
        run_str("11", 1'b0, "R1", "group 11 -> 1000");
    endtask

    task automatic t_three_bit_groups();
        run_str("000", 1'b0, "R2", "group 000 -> 000100");
        run_str("010", 1'b0, "R2", "group 010 -> 100100");
        run_str("011", 1'b0, "R2", "group 011 -> 001000");
    endtask

    task automatic t_four_bit_groups();
        run_str("0010", 1'b0, "R3", "group 0010 -> 00100100");
        run_str("0011", 1'b0, "R3", "group 0011 -> 00001000");
    endtask

    task automatic t_greedy_order();
        run_str("101001011", 1'b0, "R4", "greedy parse 10|10|010|11");
        run_str("0011000110010", 1'b0, "R4", "mixed group lengths in order");
    endtask

    task automatic t_flush_pad();
        run_str("1", 1'b1, "R8", "flush leftover 1");
        run_str("0", 1'b1, "R8", "flush leftover 0");
        run_str("1000", 1'b1, "R8", "flush leftover 00");
        run_str("01", 1'b1, "R8", "flush leftover 01");
        run_str("11001", 1'b1, "R8", "flush leftover 001");
    endtask

    // flush raised in the same clock as the last bit's handshake
    task automatic t_flush_with_last_bit();
        start_case();
        load_str("10110");
        for (int k = 0; k < n_src - 1; k++) send_bit(src[k], 1'b0);
        send_bit(src[n_src-1], 1'b1);
        check(in_ready == 1'b0, "R9", "in_ready low after flush", int'(in_ready), 0);
        wait_idle();
        build_expected();
        cmp_stream("R9", "last bit with flush");
        check(in_ready == 1'b1, "R9", "ready again after flush", int'(in_ready), 1);
    endtask

    task automatic t_continuous();
        start_case();
        for (int g = 0; g < 50; g++) add_group(int'($urandom_range(0, 6)));
        for (int k = 0; k < n_src; k++) send_bit(src[k], 1'b0);
        wait_idle();
        build_expected();
        cmp_stream("R6", "gap-free stream lossless");
        check(rises == 1, "R5", "out_valid rising edges", rises, 1);
        check(bp_seen > 0, "R6", "back-pressure seen (nonzero)", bp_seen, 1);
    endtask

    task automatic t_random_runs();
        int viol = 0;
        int zeros = 0;
        bit seen = 1'b0;
        int acc = 0;
        int alen = 0;
        int bad = -1;
        start_case();
        for (int g = 0; g < 80; g++) add_group(int'($urandom_range(0, 6)));
        case ($urandom_range(0, 5))
            0: load_str("1");
            1: load_str("0");
            2: load_str("00");
            3: load_str("01");
            4: load_str("001");
            default: ;
        endcase
        for (int k = 0; k < n_src; k++) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            send_bit(src[k], 1'b0);
        end
        pulse_flush();
        wait_idle();
        build_expected();
        cmp_stream("R7", "random stream with gaps and flush");
        for (int k = 0; k < n_got; k++) begin
            if (got[k]) begin
                if (seen && (zeros < 2 || zeros > 7)) viol++;
                seen = 1'b1;
                zeros = 0;
            end else begin
                zeros++;
            end
        end
        check(viol == 0, "R7", "zero-run bound violations", viol, 0);
        n_dec = 0;
        for (int k = 0; k < n_got; k++) begin
            acc = (acc << 1) | int'(got[k]);
            alen++;
            if (alen == 4 && acc == 'b0100) begin
                dec[n_dec] = 1; dec[n_dec+1] = 0; n_dec += 2; acc = 0; alen = 0;
            end else if (alen == 4 && acc == 'b1000) begin
                dec[n_dec] = 1; dec[n_dec+1] = 1; n_dec += 2; acc = 0; alen = 0;
            end else if (alen == 6 && acc == 'b000100) begin
                dec[n_dec] = 0; dec[n_dec+1] = 0; dec[n_dec+2] = 0; n_dec += 3; acc = 0; alen = 0;
            end else if (alen == 6 && acc == 'b100100) begin
                dec[n_dec] = 0; dec[n_dec+1] = 1; dec[n_dec+2] = 0; n_dec += 3; acc = 0; alen = 0;
            end else if (alen == 6 && acc == 'b001000) begin
                dec[n_dec] = 0; dec[n_dec+1] = 1; dec[n_dec+2] = 1; n_dec += 3; acc = 0; alen = 0;
            end else if (alen == 8 && acc == 'b00100100) begin
                dec[n_dec] = 0; dec[n_dec+1] = 0; dec[n_dec+2] = 1; dec[n_dec+3] = 0;
                n_dec += 4; acc = 0; alen = 0;
            end else if (alen == 8 && acc == 'b00001000) begin
                dec[n_dec] = 0; dec[n_dec+1] = 0; dec[n_dec+2] = 1; dec[n_dec+3] = 1;
                n_dec += 4; acc = 0; alen = 0;
            end else if (alen >= 8) begin
                if (bad < 0) bad = k;
                acc = 0; alen = 0;
            end
        end
        if (bad < 0 && (alen != 0 || n_dec < n_src)) bad = n_got;
        for (int k = 0; k < n_src; k++)
            if (bad < 0 && dec[k] !== src[k]) bad = k;
        check(bad < 0, "R7", "inverse-table decode mismatch index", bad, -1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R5 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_two_bit_groups();
        t_three_bit_groups();
        t_four_bit_groups();
        t_greedy_order();
        t_flush_pad();
        t_flush_with_last_bit();
        t_continuous();
        t_random_runs();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule